// File: doc/BRIEF.md
# Clock Root Control Register Bank

This block is the software-facing control point for a single clock root. Software writes a command word, a configuration word (input source, integer pre-divider, counter mode) and three fractional-counter values through a simple register port. All configuration writes land in shadow storage. The clock datapath only ever sees a separate set of active copies. These are replaced in one step when software commits.

To commit, software sets the update bit in the command word. The bank then raises `apply_req` toward the clock domain. When that domain answers with `apply_ack`, every shadow value is copied into the active set on that edge. At the same edge the update bit and all per-register dirty flags drop to zero. Software polls the update bit until it reads zero. The root enable bit is not double-buffered: it drives `root_en` directly. Bit 31 of the command word reads 1 whenever the root is disabled.

Top module: `clkroot_regbank`

## Requirements
- R1: Byte offsets: 0x00 command, 0x04 configuration, 0x08 M, 0x0C N, 0x10 D. The configuration word holds the divider in bits 4:0, the source select in bits 10:8 and the mode in bits 13:12. M, N and D occupy bits 7:0. Each of these reads back the last written shadow value, and all other bits read zero whatever was written.
- R2: A write to configuration, N, M or D sets the command word's dirty bit 4, 5, 6 or 7 respectively.
- R3: Writing the command word with bit 0 set makes bit 0 read 1 and raises `apply_req`. Both stay high until a commit. Writing bit 0 as zero does not clear a pending update.
- R4: On an edge where an update is pending and `apply_ack` is high, all shadow values become active together. On that same edge `apply_req`, command bit 0 and all four dirty bits clear.
- R5: Outside a commit edge, the active outputs never change, whatever the register writes.
- R6: `apply_ack` with no update pending has no effect on the active outputs or on the dirty bits.
- R7: A shadow write on the commit edge is stored in shadow but is not applied by that commit, and its dirty bit reads 1 afterwards.
- R8: Command bit 1 drives `root_en` one cycle after the write. Command bit 31 reads 1 exactly when the root is disabled.
- R9: Reset (synchronous, active high) gives source 0, divider 0, mode 0, M/N/D 0 in both shadow and active copies, no update pending, no dirty bits, root disabled (command reads 0x80000000).
- R10: A read strobe returns data on `reg_rdata` with `reg_rd_valid` high in the next cycle. The data reflects the state before any write in the strobe cycle. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | ADDR_W (5) | Byte offset |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| reg_rd_valid | output | 1 | Read data valid |
| apply_req | output | 1 | Commit pending toward clock domain |
| apply_ack | input | 1 | Clock domain ready to take new settings |
| root_en | output | 1 | Root enable to clock datapath |
| act_src | output | SRC_W (3) | Active source select |
| act_div | output | DIV_W (5) | Active pre-divider |
| act_mode | output | MODE_W (2) | Active counter mode |
| act_m | output | MND_W (8) | Active M value |
| act_n | output | MND_W (8) | Active N value |
| act_d | output | MND_W (8) | Active D value |

## Verification
The bench writes configuration words with every reserved bit set. A bank that stored reserved bits would read them back non-zero. It rewrites M while an update is pending and holds `apply_ack` off, so a design that leaked shadow values early would move the active outputs before the acknowledge. It pulses `apply_ack` with nothing pending, so a design that committed unconditionally would copy the new N value or clear its dirty flag. It also lands a shadow write on the very commit edge: a design that let the commit override the new write would lose the dirty flag, and one that forwarded the write would apply the new M too early.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  localparam int OFS_CMD = 'h00;
  localparam int OFS_CFG = 'h04;
  localparam int OFS_M   = 'h08;
  localparam int OFS_N   = 'h0C;
  localparam int OFS_D   = 'h10;

  localparam int CMD_UPD_BIT  = 0;
  localparam int CMD_EN_BIT   = 1;
  localparam int CMD_DCFG_BIT = 4;
  localparam int CMD_DN_BIT   = 5;
  localparam int CMD_DM_BIT   = 6;
  localparam int CMD_DD_BIT   = 7;
  localparam int CMD_OFF_BIT  = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;

  // dirty vector index: 0 cfg, 1 N, 2 M, 3 D
  localparam int DIRTY_W = 4;

  typedef enum logic [2:0] {
    SEL_CMD,
    SEL_CFG,
    SEL_M,
    SEL_N,
    SEL_D,
    SEL_NONE
  } rsel_e;

  function automatic rsel_e decode_addr(input logic [15:0] a);
    case (a)
      16'(OFS_CMD): decode_addr = SEL_CMD;
      16'(OFS_CFG): decode_addr = SEL_CFG;
      16'(OFS_M):   decode_addr = SEL_M;
      16'(OFS_N):   decode_addr = SEL_N;
      16'(OFS_D):   decode_addr = SEL_D;
      default:      decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/clkroot_shadow.sv
module clkroot_shadow
  import clkroot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int SRC_W  = 3,
  parameter int MODE_W = 2,
  parameter int MND_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  rsel_e              sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               commit,
  output logic [DIV_W-1:0]   sh_div,
  output logic [SRC_W-1:0]   sh_src,
  output logic [MODE_W-1:0]  sh_mode,
  output logic [MND_W-1:0]   sh_m,
  output logic [MND_W-1:0]   sh_n,
  output logic [MND_W-1:0]   sh_d,
  output logic [DIRTY_W-1:0] dirty
);
  localparam int NUM_CNT = 3;

  logic             cfg_hit;
  logic             dirty_cfg_q;
  logic [NUM_CNT-1:0] dirty_cnt_q;
  logic [MND_W-1:0] cnt_q [NUM_CNT];

  assign cfg_hit = wr_en && (sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div      <= '0;
      sh_src      <= '0;
      sh_mode     <= '0;
      dirty_cfg_q <= 1'b0;
    end else begin
      if (cfg_hit) begin
        sh_div  <= wdata[DIV_W-1:0];
        sh_src  <= wdata[CFG_SRC_LSB +: SRC_W];
        sh_mode <= wdata[CFG_MODE_LSB +: MODE_W];
      end
      // a write on the commit edge keeps its dirty flag
      dirty_cfg_q <= (dirty_cfg_q && !commit) || cfg_hit;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam rsel_e MY_SEL = (g == 0) ? SEL_M : ((g == 1) ? SEL_N : SEL_D);
    logic hit;
    assign hit = wr_en && (sel == MY_SEL);
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g]       <= '0;
        dirty_cnt_q[g] <= 1'b0;
      end else begin
        if (hit) cnt_q[g] <= wdata[MND_W-1:0];
        dirty_cnt_q[g] <= (dirty_cnt_q[g] && !commit) || hit;
      end
    end
  end

  assign sh_m  = cnt_q[0];
  assign sh_n  = cnt_q[1];
  assign sh_d  = cnt_q[2];
  assign dirty = {dirty_cnt_q[2], dirty_cnt_q[0], dirty_cnt_q[1], dirty_cfg_q};
endmodule

// File: rtl/clkroot_commit.sv
module clkroot_commit #(
  parameter int DIV_W  = 5,
  parameter int SRC_W  = 3,
  parameter int MODE_W = 2,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_set,
  input  logic              apply_ack,
  input  logic [DIV_W-1:0]  sh_div,
  input  logic [SRC_W-1:0]  sh_src,
  input  logic [MODE_W-1:0] sh_mode,
  input  logic [MND_W-1:0]  sh_m,
  input  logic [MND_W-1:0]  sh_n,
  input  logic [MND_W-1:0]  sh_d,
  output logic              pending,
  output logic              commit,
  output logic [DIV_W-1:0]  act_div,
  output logic [SRC_W-1:0]  act_src,
  output logic [MODE_W-1:0] act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  logic pending_q;

  assign pending = pending_q;
  assign commit  = pending_q && apply_ack;

  always_ff @(posedge clk) begin
    if (rst)          pending_q <= 1'b0;
    else if (upd_set) pending_q <= 1'b1;
    else if (commit)  pending_q <= 1'b0;
  end

  // whole set swaps on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div  <= '0;
      act_src  <= '0;
      act_mode <= '0;
      act_m    <= '0;
      act_n    <= '0;
      act_d    <= '0;
    end else if (commit) begin
      act_div  <= sh_div;
      act_src  <= sh_src;
      act_mode <= sh_mode;
      act_m    <= sh_m;
      act_n    <= sh_n;
      act_d    <= sh_d;
    end
  end
endmodule

// File: rtl/clkroot_rdmux.sv
module clkroot_rdmux
  import clkroot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int SRC_W  = 3,
  parameter int MODE_W = 2,
  parameter int MND_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  rsel_e              sel,
  input  logic               pending,
  input  logic               root_en,
  input  logic [DIRTY_W-1:0] dirty,
  input  logic [DIV_W-1:0]   sh_div,
  input  logic [SRC_W-1:0]   sh_src,
  input  logic [MODE_W-1:0]  sh_mode,
  input  logic [MND_W-1:0]   sh_m,
  input  logic [MND_W-1:0]   sh_n,
  input  logic [MND_W-1:0]   sh_d,
  output logic [DATA_W-1:0]  rdata,
  output logic               rd_valid
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (sel)
      SEL_CMD: begin
        word[CMD_UPD_BIT]  = pending;
        word[CMD_EN_BIT]   = root_en;
        word[CMD_DCFG_BIT] = dirty[0];
        word[CMD_DN_BIT]   = dirty[1];
        word[CMD_DM_BIT]   = dirty[2];
        word[CMD_DD_BIT]   = dirty[3];
        word[CMD_OFF_BIT]  = !root_en;
      end
      SEL_CFG: begin
        word[DIV_W-1:0]               = sh_div;
        word[CFG_SRC_LSB +: SRC_W]    = sh_src;
        word[CFG_MODE_LSB +: MODE_W]  = sh_mode;
      end
      SEL_M:   word[MND_W-1:0] = sh_m;
      SEL_N:   word[MND_W-1:0] = sh_n;
      SEL_D:   word[MND_W-1:0] = sh_d;
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= word;
    end
  end
endmodule

// File: rtl/clkroot_regbank.sv
module clkroot_regbank
  import clkroot_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int SRC_W  = 3,
  parameter int MODE_W = 2,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_valid,
  output logic              apply_req,
  input  logic              apply_ack,
  output logic              root_en,
  output logic [SRC_W-1:0]  act_src,
  output logic [DIV_W-1:0]  act_div,
  output logic [MODE_W-1:0] act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  localparam int ADDR_EXT = 16;

  rsel_e              sel;
  logic               cmd_wr;
  logic               upd_set;
  logic               pending;
  logic               commit;
  logic               root_en_q;
  logic [DIRTY_W-1:0] dirty;
  logic [DIV_W-1:0]   sh_div;
  logic [SRC_W-1:0]   sh_src;
  logic [MODE_W-1:0]  sh_mode;
  logic [MND_W-1:0]   sh_m;
  logic [MND_W-1:0]   sh_n;
  logic [MND_W-1:0]   sh_d;
  logic               unused_wdata;

  assign sel          = decode_addr(ADDR_EXT'(reg_addr));
  assign cmd_wr       = reg_wr_en && (sel == SEL_CMD);
  assign upd_set      = cmd_wr && reg_wdata[CMD_UPD_BIT];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst)         root_en_q <= 1'b0;
    else if (cmd_wr) root_en_q <= reg_wdata[CMD_EN_BIT];
  end

  assign root_en   = root_en_q;
  assign apply_req = pending;

  clkroot_shadow #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .SRC_W(SRC_W), .MODE_W(MODE_W), .MND_W(MND_W)
  ) i_shadow (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .sel(sel), .wdata(reg_wdata),
    .commit(commit), .sh_div(sh_div), .sh_src(sh_src), .sh_mode(sh_mode),
    .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d), .dirty(dirty)
  );

  clkroot_commit #(
    .DIV_W(DIV_W), .SRC_W(SRC_W), .MODE_W(MODE_W), .MND_W(MND_W)
  ) i_commit (
    .clk(clk), .rst(rst), .upd_set(upd_set), .apply_ack(apply_ack),
    .sh_div(sh_div), .sh_src(sh_src), .sh_mode(sh_mode),
    .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
    .pending(pending), .commit(commit),
    .act_div(act_div), .act_src(act_src), .act_mode(act_mode),
    .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  clkroot_rdmux #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .SRC_W(SRC_W), .MODE_W(MODE_W), .MND_W(MND_W)
  ) i_rdmux (
    .clk(clk), .rst(rst), .rd_en(reg_rd_en), .sel(sel), .pending(pending),
    .root_en(root_en_q), .dirty(dirty), .sh_div(sh_div), .sh_src(sh_src),
    .sh_mode(sh_mode), .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
    .rdata(reg_rdata), .rd_valid(reg_rd_valid)
  );
endmodule

// File: rtl/clkroot_regbank_chk.sv
module clkroot_regbank_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int SRC_W  = 3,
  parameter int MODE_W = 2,
  parameter int MND_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wdata_upd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rd_valid,
  input logic              apply_req,
  input logic              apply_ack,
  input logic              root_en,
  input logic [SRC_W-1:0]  act_src,
  input logic [DIV_W-1:0]  act_div,
  input logic [MODE_W-1:0] act_mode,
  input logic [MND_W-1:0]  act_m,
  input logic [MND_W-1:0]  act_n,
  input logic [MND_W-1:0]  act_d
);
  logic cmd_sel;
  assign cmd_sel = (reg_addr == '0);

  AST_UPD_RAISE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && cmd_sel && wdata_upd) |=> apply_req); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (apply_req && !apply_ack) |=> apply_req); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (apply_req && apply_ack && !(reg_wr_en && cmd_sel && wdata_upd)) |=> !apply_req); // R4

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(apply_req && apply_ack) |=> $stable({act_src, act_div, act_mode, act_m, act_n, act_d})); // R5

  AST_OFF_STATUS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !reg_wr_en && cmd_sel) |=> (reg_rdata[DATA_W-1] == !root_en)); // R8

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rd_valid); // R10

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> !reg_rd_valid); // R10
endmodule

bind clkroot_regbank clkroot_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
  .SRC_W(SRC_W), .MODE_W(MODE_W), .MND_W(MND_W)
) i_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .wdata_upd(reg_wdata[0]), .reg_rdata(reg_rdata),
  .reg_rd_valid(reg_rd_valid), .apply_req(apply_req), .apply_ack(apply_ack),
  .root_en(root_en), .act_src(act_src), .act_div(act_div), .act_mode(act_mode),
  .act_m(act_m), .act_n(act_n), .act_d(act_d)
);

// File: tb/test_clkroot_regbank.sv
module test_clkroot_regbank;
  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_M = 5'h08, A_N = 5'h0C, A_D = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, apply_ack = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rd_valid, apply_req, root_en;
  logic [2:0]  act_src;
  logic [4:0]  act_div;
  logic [1:0]  act_mode;
  logic [7:0]  act_m, act_n, act_d;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  clkroot_regbank i_clkroot_regbank (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid), .apply_req(apply_req), .apply_ack(apply_ack),
    .root_en(root_en), .act_src(act_src), .act_div(act_div), .act_mode(act_mode),
    .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the bank returns it
  always @(negedge clk) begin
    if (reg_rd_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected read data", 64'(reg_rdata), 64'hx);
      else chk(tag_q.pop_front(), 64'(reg_rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic ack_pulse();
    apply_ack = 1'b1;
    @(negedge clk);
    apply_ack = 1'b0;
  endtask

  function automatic logic [63:0] act_all();
    return 64'({act_src, act_div, act_mode, act_m, act_n, act_d});
  endfunction

  function automatic logic [63:0] pack(input logic [2:0] s, input logic [4:0] dv,
                                      input logic [1:0] md, input logic [7:0] m,
                                      input logic [7:0] n, input logic [7:0] d);
    return 64'({s, dv, md, m, n, d});
  endfunction

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R10 reads outstanding", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 apply_req after reset", 64'(apply_req), 64'd0);
    chk("R9 root_en after reset", 64'(root_en), 64'd0);
    chk("R9 active after reset", act_all(), 64'd0);
    rd(A_CMD, 32'h8000_0000, "R9 cmd after reset");
    rd(A_CFG, 32'h0, "R9 cfg after reset");
    rd(A_D, 32'h0, "R9 D after reset");

    // R1 config with every reserved bit set
    wr(A_CFG, 32'hFFFF_EBE5);
    rd(A_CFG, 32'h0000_2305, "R1 cfg fields, reserved zero");
    rd(A_CMD, 32'h8000_0010, "R2 cfg dirty");
    chk("R5 active before commit", act_all(), 64'd0);

    wr(A_M, 32'hFFFF_FF03);
    wr(A_N, 32'h0000_00FA);
    wr(A_D, 32'hABCD_12F7);
    rd(A_M, 32'h03, "R1 M readback");
    rd(A_N, 32'hFA, "R1 N readback");
    rd(A_D, 32'hF7, "R1 D readback");
    rd(A_CMD, 32'h8000_00F0, "R2 all dirty");

    // R3 request commit and enable root
    wr(A_CMD, 32'h3);
    chk("R3 apply_req raised", 64'(apply_req), 64'd1);
    chk("R8 root_en follows cmd", 64'(root_en), 64'd1);
    rd(A_CMD, 32'h0000_00F3, "R3 R8 cmd pending");
    wr(A_CMD, 32'h2);
    chk("R3 zero write keeps pending", 64'(apply_req), 64'd1);
    wr(A_M, 32'h05);
    repeat (3) @(negedge clk);
    chk("R5 active held while pending", act_all(), 64'd0);
    chk("R3 still pending", 64'(apply_req), 64'd1);

    // R4 commit
    ack_pulse();
    chk("R4 all fields applied", act_all(), pack(3'd3, 5'd5, 2'd2, 8'h05, 8'hFA, 8'hF7));
    chk("R4 apply_req cleared", 64'(apply_req), 64'd0);
    rd(A_CMD, 32'h0000_0002, "R4 update and dirty cleared");

    // R6 stray acknowledge
    wr(A_N, 32'h11);
    ack_pulse();
    chk("R6 stray ack ignored", act_all(), pack(3'd3, 5'd5, 2'd2, 8'h05, 8'hFA, 8'hF7));
    rd(A_CMD, 32'h0000_0022, "R6 N dirty kept");

    // R7 shadow write on the commit edge
    wr(A_CMD, 32'h3);
    reg_wr_en = 1'b1; reg_addr = A_M; reg_wdata = 32'h07; apply_ack = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; apply_ack = 1'b0;
    chk("R7 commit-edge write not applied", 64'(act_m), 64'h05);
    chk("R4 pending N applied", 64'(act_n), 64'h11);
    chk("R4 apply_req cleared again", 64'(apply_req), 64'd0);
    rd(A_M, 32'h07, "R7 shadow holds new M");
    rd(A_CMD, 32'h0000_0042, "R7 M dirty survives");

    // R10 unmapped offsets
    rd(5'h14, 32'h0, "R10 unmapped 0x14");
    rd(5'h1C, 32'h0, "R10 unmapped 0x1C");

    // R8 disable root
    wr(A_CMD, 32'h0);
    chk("R8 root_en low", 64'(root_en), 64'd0);
    rd(A_CMD, 32'h8000_0040, "R8 root off status");

    // R9 reset in mid-operation
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R9 active after second reset", act_all(), 64'd0);
    rd(A_CMD, 32'h8000_0000, "R9 cmd after second reset");
    rd(A_M, 32'h0, "R9 M after second reset");

    finish_run();
  end
endmodule